// File: doc/BRIEF.md
# Z80 Banked Memory Mapper

This block sits between a Z80 bus and the memories of a small palmtop that carries 256KB of ROM and 128KB of RAM. It splits the 64KB logical space into four 16KB windows, chosen by logical bits A15 and A14. The lowest window is wired to ROM bank 0 and the highest to RAM bank 0. Each of the two middle windows is steered by its own byte-wide bank register.

A bank register is written with an OUT to its I/O port and returned by an IN from the same port. In each register, one bit picks the device, ROM or RAM. The low bits pick the bank within that device. ROM and RAM share the high physical address lines; only the ROM uses the top one.

The physical address, the active-low ROM enable and the active-high RAM enable are all registered. They follow the CPU bus with one clock of latency.

Top module: `zbm_mapper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `phys_addr` is 0, `rom_ce_n` is 1, `ram_ce` is 0, `io_rvalid` is 0 and `io_rdata` is 0. After reset both bank registers read back as 0x00, so both middle windows show ROM bank 0.
- R2: A memory access to logical 0x0000–0x3FFF selects ROM (`rom_ce_n`=0, `ram_ce`=0) with `phys_addr[17:14]`=0.
- R3: A memory access to logical 0xC000–0xFFFF selects RAM (`ram_ce`=1, `rom_ce_n`=1) with `phys_addr[17:14]`=0.
- R4: Logical 0x4000–0x7FFF is steered by the register at I/O port 0x05. Logical 0x8000–0xBFFF is steered by the register at I/O port 0x06.
- R5: In a bank register, bit 6 = 0 selects ROM and bit 6 = 1 selects RAM.
- R6: For ROM, register bits 3:0 appear on `phys_addr[17:14]`.
- R7: For RAM, register bits 2:0 appear on `phys_addr[16:14]`, and `phys_addr[17]` is 0. Bit 3 is ignored, so RAM bank numbers wrap modulo 8.
- R8: Logical bits A13–A0 appear unchanged on `phys_addr[13:0]`.
- R9: A chip enable is active only for a cycle in which `mreq_n` was low, and the two enables are never active together.
- R10: A register is written only when `iorq_n` and `wr_n` are both low and `cpu_addr[7:0]` equals its port. The upper address byte is not decoded. Writes to other ports, and memory writes, leave both registers unchanged.
- R11: An I/O read (`iorq_n`=0, `rd_n`=0) from port 0x05 or 0x06 returns the whole stored byte on `io_rdata` with `io_rvalid`=1 one cycle later. Any other port gives `io_rvalid`=0 and `io_rdata`=0.
- R12: Outputs change one clock after the bus inputs are sampled. A register write is seen by the very next memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_wdata | input | 8 | CPU data byte for I/O writes |
| io_rdata | output | 8 | Bank register readback byte |
| io_rvalid | output | 1 | Readback byte valid |
| phys_addr | output | 18 | Physical address shared by ROM and RAM |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| ram_ce | output | 1 | RAM chip enable, active high |

## Verification
The assertions assume a Z80-like bus. `mreq_n` and `iorq_n` are never low in the same cycle. A strobe is asserted only together with one of the two requests. Each bus input is held stable for a whole clock.

The bench drives every transfer from tasks that change the inputs at the falling edge and return the bus to idle afterwards. This keeps memory and I/O cycles apart and makes each output comparable with the address issued one clock earlier.

// File: rtl/zbm_pkg.sv
package zbm_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int OFFS_W     = 14;
  localparam int ROM_BANK_W = 4;
  localparam int RAM_BANK_W = 3;
  localparam int PHYS_W     = OFFS_W + ROM_BANK_W;
  localparam int SEL_BIT    = 6;
  localparam int NUM_WIN    = 2;

  typedef enum logic {
    DEV_ROM = 1'b0,
    DEV_RAM = 1'b1
  } dev_e;

  typedef struct packed {
    dev_e                  dev;
    logic [ROM_BANK_W-1:0] bank;
  } target_t;
endpackage

// File: rtl/zbm_bank_regs.sv
module zbm_bank_regs #(
  parameter int          NUM_WIN   = zbm_pkg::NUM_WIN,
  parameter int          DATA_W    = zbm_pkg::DATA_W,
  parameter logic [7:0]  PORT_BASE = 8'h05
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [7:0]                     io_addr,
  input  logic                           iorq_n,
  input  logic                           rd_n,
  input  logic                           wr_n,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_WIN-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]              rdata,
  output logic                           rvalid
);
  logic              io_wr;
  logic              io_rd;
  logic [NUM_WIN-1:0] hit;

  assign io_wr = !iorq_n && !wr_n;
  assign io_rd = !iorq_n && !rd_n;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_reg
    localparam logic [7:0] PORT = PORT_BASE + 8'(w);
    assign hit[w] = (io_addr == PORT);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[w] <= '0;
      end else if (io_wr && hit[w]) begin
        regs[w] <= wdata;
      end
    end
  end

  logic [DATA_W-1:0] rd_mux;
  logic              rd_any;

  always_comb begin
    rd_mux = '0;
    rd_any = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit[w]) begin
        rd_mux = regs[w];
        rd_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (io_rd && rd_any) begin
      rdata  <= rd_mux;
      rvalid <= 1'b1;
    end else begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/zbm_window_map.sv
module zbm_window_map
  import zbm_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  parameter int OW      = OFFS_W,
  parameter int ROM_W   = ROM_BANK_W,
  parameter int RAM_W   = RAM_BANK_W,
  parameter int SEL     = SEL_BIT,
  parameter int NWIN    = NUM_WIN
) (
  input  logic [AW-1:0]            cpu_addr,
  input  logic [NWIN-1:0][DW-1:0]  regs,
  output target_t                  target,
  output logic [OW-1:0]            offset
);
  target_t win_tgt [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [ROM_W-1:0] ram_bank;
    always_comb begin
      ram_bank = '0;
      ram_bank[RAM_W-1:0] = regs[w][RAM_W-1:0];
      win_tgt[w].dev  = dev_e'(regs[w][SEL]);
      win_tgt[w].bank = regs[w][SEL] ? ram_bank : regs[w][ROM_W-1:0];
    end
    logic unused_hi;
    assign unused_hi = ^{regs[w][DW-1:SEL+1], regs[w][SEL-1:ROM_W]};
  end

  logic [1:0] win;
  assign win    = cpu_addr[AW-1 -: 2];
  assign offset = cpu_addr[OW-1:0];

  always_comb begin
    case (win)
      2'b00:   target = '{dev: DEV_ROM, bank: '0};
      2'b01:   target = win_tgt[0];
      2'b10:   target = win_tgt[NWIN-1];
      default: target = '{dev: DEV_RAM, bank: '0};
    endcase
  end
endmodule

// File: rtl/zbm_out_stage.sv
module zbm_out_stage
  import zbm_pkg::*;
#(
  parameter int PW = PHYS_W,
  parameter int OW = OFFS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_req,
  input  target_t       target,
  input  logic [OW-1:0] offset,
  output logic [PW-1:0] phys_addr,
  output logic          rom_ce_n,
  output logic          ram_ce
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      rom_ce_n  <= 1'b1;
      ram_ce    <= 1'b0;
    end else begin
      phys_addr <= {target.bank, offset};
      rom_ce_n  <= !(mem_req && target.dev == DEV_ROM);
      ram_ce    <= mem_req && target.dev == DEV_RAM;
    end
  end
endmodule

// File: rtl/zbm_mapper.sv
module zbm_mapper
  import zbm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               mreq_n,
  input  logic               iorq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic [DATA_W-1:0]  io_rdata,
  output logic               io_rvalid,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic               rom_ce_n,
  output logic               ram_ce
);
  logic [NUM_WIN-1:0][DATA_W-1:0] regs;
  target_t                        target;
  logic [OFFS_W-1:0]              offset;

  zbm_bank_regs #(
    .NUM_WIN   (NUM_WIN),
    .DATA_W    (DATA_W),
    .PORT_BASE (8'h05)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .io_addr(cpu_addr[7:0]),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .wdata  (io_wdata),
    .regs   (regs),
    .rdata  (io_rdata),
    .rvalid (io_rvalid)
  );

  zbm_window_map u_map (
    .cpu_addr(cpu_addr),
    .regs    (regs),
    .target  (target),
    .offset  (offset)
  );

  zbm_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (!mreq_n),
    .target   (target),
    .offset   (offset),
    .phys_addr(phys_addr),
    .rom_ce_n (rom_ce_n),
    .ram_ce   (ram_ce)
  );
endmodule

// File: rtl/zbm_mapper_checker.sv
module zbm_mapper_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic        mreq_n,
  input logic        iorq_n,
  input logic        rd_n,
  input logic        io_rvalid,
  input logic [17:0] phys_addr,
  input logic        rom_ce_n,
  input logic        ram_ce
);
  assert_ce_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(!rom_ce_n && ram_ce));

  assert_ce_needs_mreq_R9: assert property (@(posedge clk) disable iff (rst)
    $past(mreq_n) |-> (rom_ce_n && !ram_ce));

  assert_offset_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mreq_n)) |-> phys_addr[13:0] == $past(cpu_addr[13:0]));

  assert_low_window_rom_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mreq_n) && $past(cpu_addr[15:14]) == 2'b00)
      |-> (!rom_ce_n && phys_addr[17:14] == 4'd0));

  assert_high_window_ram_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mreq_n) && $past(cpu_addr[15:14]) == 2'b11)
      |-> (ram_ce && phys_addr[17:14] == 4'd0));

  assert_ram_top_line_R7: assert property (@(posedge clk) disable iff (rst)
    ram_ce |-> !phys_addr[17]);

  assert_readback_valid_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(iorq_n) && !$past(rd_n) &&
     ($past(cpu_addr[7:0]) == 8'h05 || $past(cpu_addr[7:0]) == 8'h06))
      |-> io_rvalid);
endmodule

bind zbm_mapper zbm_mapper_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .mreq_n   (mreq_n),
  .iorq_n   (iorq_n),
  .rd_n     (rd_n),
  .io_rvalid(io_rvalid),
  .phys_addr(phys_addr),
  .rom_ce_n (rom_ce_n),
  .ram_ce   (ram_ce)
);

// File: tb/zbm_mapper_tb.sv
`timescale 1ns/1ps
module zbm_mapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic [17:0] phys_addr;
  logic        rom_ce_n, ram_ce;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zbm_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid), .phys_addr(phys_addr),
    .rom_ce_n(rom_ce_n), .ram_ce(ram_ce)
  );

  // {reg05, reg06, logical addr, expected phys, expected ram select}
  localparam int NV = 11;
  localparam logic [50:0] VEC [NV] = '{
    {8'h00, 8'h00, 16'h1234, 18'h01234, 1'b0},
    {8'h03, 8'h00, 16'h4ABC, 18'h0CABC, 1'b0},
    {8'h0F, 8'h00, 16'h7FFF, 18'h3FFFF, 1'b0},
    {8'h00, 8'h45, 16'h8001, 18'h14001, 1'b1},
    {8'h00, 8'h4F, 16'hBFFF, 18'h1FFFF, 1'b1},
    {8'h4A, 8'h0E, 16'h5555, 18'h09555, 1'b1},
    {8'h4A, 8'h0E, 16'hA5A5, 18'h3A5A5, 1'b0},
    {8'hC7, 8'h00, 16'hFFFF, 18'h03FFF, 1'b1},
    {8'hFF, 8'hFF, 16'h0000, 18'h00000, 1'b0},
    {8'hB9, 8'h00, 16'h6000, 18'h26000, 1'b0},
    {8'h01, 8'h48, 16'h9234, 18'h01234, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; io_wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    cpu_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    d = io_rdata; v = io_rvalid;
    bus_idle();
  endtask

  task automatic mem_rd(input logic [15:0] a, output logic [17:0] p,
                        output logic rce_n, output logic ace);
    @(negedge clk);
    cpu_addr = a; mreq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    p = phys_addr; rce_n = rom_ce_n; ace = ram_ce;
    bus_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [17:0] p;
    logic        rce_n, ace, v;
    logic [7:0]  d;

    // R1: outputs held inactive during reset, even with a memory request
    cpu_addr = 16'h4321; mreq_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(phys_addr == 0 && rom_ce_n && !ram_ce && !io_rvalid && io_rdata == 0,
          "R1 reset outputs", {13'd0, phys_addr, rom_ce_n}, 32'h1);
    bus_idle();
    @(negedge clk); rst = 1'b0;
    io_read(16'h0005, d, v);
    check(v && d == 8'h00, "R1 reset reg05", {23'd0, v, d}, 32'h100);
    io_read(16'h0006, d, v);
    check(v && d == 8'h00, "R1 reset reg06", {23'd0, v, d}, 32'h100);
    mem_rd(16'h8123, p, rce_n, ace);
    check(p == 18'h00123 && !rce_n && !ace, "R1 window B after reset", p, 32'h00123);

    // R2..R8, R12: vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  ra, rb;
      logic [15:0] la;
      logic [17:0] ep;
      logic        er;
      {ra, rb, la, ep, er} = VEC[i];
      io_write(16'h0005, ra);
      io_write(16'h0006, rb);
      mem_rd(la, p, rce_n, ace);
      check(p == ep, "R4/R6/R7/R8 phys_addr", p, ep);
      check(ace == er && rce_n == er, "R2/R3/R5 chip enables",
            {30'd0, ace, rce_n}, {30'd0, er, er});
    end

    // R12: write then immediately access sees new bank
    io_write(16'h0005, 8'h0C);
    mem_rd(16'h4000, p, rce_n, ace);
    check(p == 18'h30000 && !rce_n, "R12 write seen by next access", p, 32'h30000);

    // R9: no enable without a memory request
    @(negedge clk); cpu_addr = 16'hC000; rd_n = 1'b0;
    @(negedge clk);
    check(rom_ce_n && !ram_ce, "R9 no mreq no enable", {30'd0, ram_ce, rom_ce_n}, 32'h1);
    bus_idle();

    // R10: other port and memory write leave registers unchanged
    io_write(16'h0006, 8'h45);
    io_write(16'h0007, 8'h4F);
    io_read(16'h0005, d, v);
    check(d == 8'h0C, "R10 port 07 ignored (reg05)", d, 32'h0C);
    io_read(16'h0006, d, v);
    check(d == 8'h45, "R10 port 07 ignored (reg06)", d, 32'h45);
    @(negedge clk); cpu_addr = 16'h0005; io_wdata = 8'hEE; mreq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); bus_idle();
    io_read(16'h0005, d, v);
    check(d == 8'h0C, "R10 memory write ignored", d, 32'h0C);
    @(negedge clk); cpu_addr = 16'h0006; io_wdata = 8'hEE; iorq_n = 1'b0;
    @(negedge clk); bus_idle();
    io_read(16'h0006, d, v);
    check(d == 8'h45, "R10 iorq without wr ignored", d, 32'h45);
    io_write(16'hAB06, 8'h42);
    io_read(16'h3C06, d, v);
    check(d == 8'h42 && v, "R10 upper byte not decoded", d, 32'h42);
    mem_rd(16'h8010, p, rce_n, ace);
    check(p == 18'h08010 && ace, "R10 new reg06 in window B", p, 32'h08010);

    // R11: readback of unmapped port gives nothing
    io_read(16'h0007, d, v);
    check(!v && d == 0, "R11 unmapped port readback", {23'd0, v, d}, 32'h0);
    io_write(16'h0005, 8'hB3);
    io_read(16'h0005, d, v);
    check(v && d == 8'hB3, "R11 full byte readback", d, 32'hB3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule